// File: doc/BRIEF.md
# Radio Link Hyperframe Timing Framer

This block keeps the transmit-side timing position of a serial radio fronthaul link. Each pulse on the word strobe moves it on by one word slot. Four cascaded counters hold the position: the word within a basic frame, the basic frame within a hyperframe, the hyperframe within a 10 ms frame, and a 12-bit 10 ms frame number. The block always presents the slot it currently holds. The outputs are the four indices, a flag that is high when the slot is the control word, and pulses that mark the first word of a hyperframe and of a 10 ms frame.

In the control slot the block also drives the control word. It inserts the bytes that carry timing: the start-of-hyperframe sync character and the hyperframe number, and the frame number split across two bytes. It drives every other control byte as zero, so that other control sources can OR their own content into those bytes. Line coding, serialization and the IQ payload are handled downstream.

The word strobe is a plain pacing input and carries no data, so the block has no valid/ready handshake and applies no back-pressure. A consumer that stalls holds the strobe low, and the block then keeps its current slot for as long as needed. When the strobe is sampled high, the slot is taken as consumed and the next slot appears one clock later.

Top module: `hfr_timing_framer`

## Requirements
- R1: The word index starts at 0. It rises by one on each clock edge at which `word_stb` is high, and wraps from 15 to 0. While `word_stb` is low, none of the four counters changes.
- R2: The basic-frame index rises by one when the word index wraps, and wraps itself from 255 to 0.
- R3: The hyperframe index rises by one when the word and basic-frame indices wrap together, and wraps itself from 149 to 0.
- R4: The frame number rises by one when the hyperframe index wraps from 149 to 0, and wraps from 4095 to 0.
- R5: `is_ctrl` is high exactly when the word index is 0.
- R6: In the control slot of basic frame 0, byte 0 (bits 7..0) carries the sync code and bit 0 of `ctrl_k` is 1. With `USE_K` = 1 the sync code is 8'hBC. With `USE_K` = 0 it is 8'h50 and the K flag stays 0.
- R7: In the control slot of basic frame 64, byte 0 carries the hyperframe index.
- R8: In the control slot of basic frame 128, byte 0 carries bits 7..0 of the frame number.
- R9: In the control slot of basic frame 192, byte 0 bits 3..0 carry frame-number bits 11..8, and bits 7..4 are 0.
- R10: All other control bytes are 0. This covers byte 0 at every other basic frame and every byte above byte 0. The whole of `ctrl_data` and `ctrl_k` is 0 in non-control slots, and `ctrl_k` is 0 everywhere except in the sync slot.
- R11: `hf_start` is high exactly when the word and basic-frame indices are both 0. `frame_start` is high exactly when, in addition, the hyperframe index is 0.
- R12: A synchronous `rst` returns all four counters to 0, so the first slot after reset is word 0, basic frame 0, hyperframe 0, frame number 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| word_stb | input | 1 | Current word slot consumed; advance to the next |
| w_idx | output | $clog2(WORDS_PER_BF) | Word index within the basic frame |
| x_idx | output | $clog2(BF_PER_HF) | Basic-frame index within the hyperframe |
| z_idx | output | $clog2(HF_PER_FRAME) | Hyperframe index within the 10 ms frame |
| frame_num | output | FN_W | 10 ms frame number |
| is_ctrl | output | 1 | Current slot is the control word |
| ctrl_data | output | 8*CW_BYTES | Control word content, byte Y at bits 8Y+7..8Y |
| ctrl_k | output | CW_BYTES | K-character flag per control byte |
| hf_start | output | 1 | First word of a hyperframe |
| frame_start | output | 1 | First word of a 10 ms frame |

## Verification
A counter that enables on the wrong carry shows up within one hyperframe, as an index out of step at the ports or a pulse in the wrong slot. A wrong frame-number carry is caught when the embedded bytes of the next hyperframe are read. A mis-decoded control slot shows as a wrong or non-zero byte at one of the four timing basic frames. A K flag raised outside the sync slot is caught at that slot. A reduced configuration covers every slot of more than 512 complete frames, with gaps in the strobe, so every carry and both frame-number bytes are compared with an arithmetic model. It also ends with a reset taken in the middle of a frame.

// File: rtl/hfr_pkg.sv
package hfr_pkg;
  localparam logic [7:0] SYNC_K_CHAR     = 8'hBC;
  localparam logic [7:0] SYNC_BLOCK_CODE = 8'h50;

  typedef enum logic [2:0] {
    SLOT_PLAIN,
    SLOT_SYNC,
    SLOT_HFN,
    SLOT_FN_LO,
    SLOT_FN_HI
  } ctrl_slot_e;
endpackage

// File: rtl/hfr_wrap_counter.sv
module hfr_wrap_counter #(
  parameter int MAX = 16,
  localparam int CW = $clog2(MAX)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          en,
  output logic [CW-1:0] count,
  output logic          last
);
  assign last = (count == CW'(MAX - 1));

  always_ff @(posedge clk) begin
    if (rst)
      count <= '0;
    else if (en)
      count <= last ? '0 : count + CW'(1);
  end

  // every level of the chain: R1, R3 and R4 rely on the same wrap
  assert_wrap_to_zero_R2: assert property (@(posedge clk) disable iff (rst)
    (en && last) |=> (count == '0));
  assert_step_R1: assert property (@(posedge clk) disable iff (rst)
    (en && !last) |=> (count == $past(count) + CW'(1)));
endmodule

// File: rtl/hfr_ctrl_gen.sv
module hfr_ctrl_gen import hfr_pkg::*; #(
  parameter int BF_PER_HF    = 256,
  parameter int HF_PER_FRAME = 150,
  parameter int FN_W         = 12,
  parameter int CW_BYTES     = 1,
  parameter int USE_K        = 1,
  localparam int XW = $clog2(BF_PER_HF),
  localparam int ZW = $clog2(HF_PER_FRAME)
) (
  input  logic                  is_ctrl,
  input  logic [XW-1:0]         x,
  input  logic [ZW-1:0]         z,
  input  logic [FN_W-1:0]       fn,
  output logic [8*CW_BYTES-1:0] data,
  output logic [CW_BYTES-1:0]   k
);
  localparam int         QUARTER   = BF_PER_HF / 4;
  localparam logic [7:0] SYNC_CODE = (USE_K != 0) ? SYNC_K_CHAR : SYNC_BLOCK_CODE;
  localparam logic       SYNC_K    = (USE_K != 0);

  ctrl_slot_e slot;
  logic [7:0] byte0;
  logic       k0;

  always_comb begin
    if (!is_ctrl)                     slot = SLOT_PLAIN;
    else if (x == '0)                 slot = SLOT_SYNC;
    else if (x == XW'(QUARTER))       slot = SLOT_HFN;
    else if (x == XW'(2 * QUARTER))   slot = SLOT_FN_LO;
    else if (x == XW'(3 * QUARTER))   slot = SLOT_FN_HI;
    else                              slot = SLOT_PLAIN;
  end

  always_comb begin
    byte0 = '0;
    k0    = 1'b0;
    case (slot)
      SLOT_SYNC:  begin byte0 = SYNC_CODE; k0 = SYNC_K; end
      SLOT_HFN:   byte0 = 8'(z);
      SLOT_FN_LO: byte0 = fn[7:0];
      SLOT_FN_HI: byte0 = 8'(fn >> 8);
      default:    byte0 = '0;
    endcase
  end

  assign data[7:0] = byte0;
  assign k[0]      = k0;

  generate
    if (CW_BYTES > 1) begin : g_upper
      assign data[8*CW_BYTES-1:8] = '0;
      assign k[CW_BYTES-1:1]      = '0;
    end
  endgenerate
endmodule

// File: rtl/hfr_timing_framer.sv
module hfr_timing_framer #(
  parameter int WORDS_PER_BF = 16,
  parameter int BF_PER_HF    = 256,
  parameter int HF_PER_FRAME = 150,
  parameter int FN_W         = 12,
  parameter int CW_BYTES     = 1,
  parameter int USE_K        = 1,
  localparam int WW = $clog2(WORDS_PER_BF),
  localparam int XW = $clog2(BF_PER_HF),
  localparam int ZW = $clog2(HF_PER_FRAME)
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  word_stb,
  output logic [WW-1:0]         w_idx,
  output logic [XW-1:0]         x_idx,
  output logic [ZW-1:0]         z_idx,
  output logic [FN_W-1:0]       frame_num,
  output logic                  is_ctrl,
  output logic [8*CW_BYTES-1:0] ctrl_data,
  output logic [CW_BYTES-1:0]   ctrl_k,
  output logic                  hf_start,
  output logic                  frame_start
);
  localparam int FN_MAX = 1 << FN_W;

  logic w_last, x_last, z_last, f_last;
  logic x_en, z_en, f_en;

  assign x_en = word_stb & w_last;
  assign z_en = x_en & x_last;
  assign f_en = z_en & z_last;

  hfr_wrap_counter #(.MAX(WORDS_PER_BF)) u_word (
    .clk(clk), .rst(rst), .en(word_stb), .count(w_idx), .last(w_last));
  hfr_wrap_counter #(.MAX(BF_PER_HF)) u_bf (
    .clk(clk), .rst(rst), .en(x_en), .count(x_idx), .last(x_last));
  hfr_wrap_counter #(.MAX(HF_PER_FRAME)) u_hf (
    .clk(clk), .rst(rst), .en(z_en), .count(z_idx), .last(z_last));
  hfr_wrap_counter #(.MAX(FN_MAX)) u_fn (
    .clk(clk), .rst(rst), .en(f_en), .count(frame_num), .last(f_last));

  assign is_ctrl     = (w_idx == '0);
  assign hf_start    = is_ctrl && (x_idx == '0);
  assign frame_start = hf_start && (z_idx == '0);

  hfr_ctrl_gen #(
    .BF_PER_HF(BF_PER_HF), .HF_PER_FRAME(HF_PER_FRAME), .FN_W(FN_W),
    .CW_BYTES(CW_BYTES), .USE_K(USE_K)
  ) u_ctrl (
    .is_ctrl(is_ctrl), .x(x_idx), .z(z_idx), .fn(frame_num),
    .data(ctrl_data), .k(ctrl_k));

  assert_hold_no_strobe_R1: assert property (@(posedge clk) disable iff (rst)
    !word_stb |=> $stable({w_idx, x_idx, z_idx, frame_num}));
  assert_fn_advance_R4: assert property (@(posedge clk) disable iff (rst)
    (word_stb && w_last && x_last && z_last) |=> (frame_num == $past(frame_num) + FN_W'(1)));
  assert_fn_steady_R4: assert property (@(posedge clk) disable iff (rst)
    !(word_stb && w_last && x_last && z_last) |=> $stable(frame_num));
  assert_k_only_sync_R6: assert property (@(posedge clk) disable iff (rst)
    (ctrl_k != '0) |-> (w_idx == '0 && x_idx == '0));
  assert_data_quiet_R10: assert property (@(posedge clk) disable iff (rst)
    !is_ctrl |-> (ctrl_data == '0 && ctrl_k == '0));
  assert_frame_in_hf_R11: assert property (@(posedge clk) disable iff (rst)
    frame_start |-> hf_start);
  assert_reset_zero_R12: assert property (@(posedge clk)
    rst |=> (w_idx == '0 && x_idx == '0 && z_idx == '0 && frame_num == '0));
endmodule

// File: tb/hfr_timing_framer_test.sv
module hfr_timing_framer_test;
  localparam int WPB = 2;
  localparam int BPH = 4;
  localparam int HPF = 3;
  localparam int FNW = 9;
  localparam int CWB = 2;
  localparam int WW  = $clog2(WPB);
  localparam int XW  = $clog2(BPH);
  localparam int ZW  = $clog2(HPF);
  localparam int Q   = BPH / 4;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic word_stb = 1'b0;
  logic [WW-1:0] w_idx;
  logic [XW-1:0] x_idx;
  logic [ZW-1:0] z_idx;
  logic [FNW-1:0] frame_num;
  logic is_ctrl, hf_start, frame_start;
  logic [8*CWB-1:0] ctrl_data;
  logic [CWB-1:0] ctrl_k;

  int checks = 0;
  int errors = 0;
  int mw = 0, mx = 0, mz = 0, mf = 0;
  int fn_wraps = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  hfr_timing_framer #(
    .WORDS_PER_BF(WPB), .BF_PER_HF(BPH), .HF_PER_FRAME(HPF),
    .FN_W(FNW), .CW_BYTES(CWB), .USE_K(1)
  ) uut (
    .clk(clk), .rst(rst), .word_stb(word_stb), .w_idx(w_idx), .x_idx(x_idx),
    .z_idx(z_idx), .frame_num(frame_num), .is_ctrl(is_ctrl),
    .ctrl_data(ctrl_data), .ctrl_k(ctrl_k), .hf_start(hf_start),
    .frame_start(frame_start));

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d (w=%0d x=%0d z=%0d f=%0d)",
               tag, act, exp, mw, mx, mz, mf);
    end
  endtask

  task automatic check_slot();
    int exp_b0;
    string tag;
    exp_b0 = 0;
    tag = "R10";
    if (mw == 0) begin
      if (mx == 0)          begin exp_b0 = 8'hBC; tag = "R6"; end
      else if (mx == Q)     begin exp_b0 = mz; tag = "R7"; end
      else if (mx == 2 * Q) begin exp_b0 = mf % 256; tag = "R8"; end
      else if (mx == 3 * Q) begin exp_b0 = mf / 256; tag = "R9"; end
    end
    chk(int'(w_idx) == mw, "R1", int'(w_idx), mw);
    chk(int'(x_idx) == mx, "R2", int'(x_idx), mx);
    chk(int'(z_idx) == mz, "R3", int'(z_idx), mz);
    chk(int'(frame_num) == mf, "R4", int'(frame_num), mf);
    chk(is_ctrl == (mw == 0), "R5", int'(is_ctrl), int'(mw == 0));
    chk(int'(ctrl_data[7:0]) == exp_b0, tag, int'(ctrl_data[7:0]), exp_b0);
    chk(ctrl_data[15:8] == 8'h00, "R10", int'(ctrl_data[15:8]), 0);
    chk(int'(ctrl_k) == ((mw == 0 && mx == 0) ? 1 : 0), "R6", int'(ctrl_k),
        (mw == 0 && mx == 0) ? 1 : 0);
    chk(hf_start == (mw == 0 && mx == 0), "R11", int'(hf_start),
        int'(mw == 0 && mx == 0));
    chk(frame_start == (mw == 0 && mx == 0 && mz == 0), "R11", int'(frame_start),
        int'(mw == 0 && mx == 0 && mz == 0));
  endtask

  task automatic model_step();
    if (mw == WPB - 1) begin
      mw = 0;
      if (mx == BPH - 1) begin
        mx = 0;
        if (mz == HPF - 1) begin
          mz = 0;
          if (mf == (1 << FNW) - 1) begin mf = 0; fn_wraps++; end
          else mf++;
        end else mz++;
      end else mx++;
    end else mw++;
  endtask

  initial begin
    int total;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    // R12: first slot after reset
    check_slot();
    total = (513 * WPB * BPH * HPF) + 7;
    for (int i = 0; i < total * 2 && !done; i++) begin
      word_stb = (i % 7) != 6;   // gaps exercise the R1 hold
      @(posedge clk);
      if (word_stb) model_step();
      @(negedge clk);
      check_slot();
      if (fn_wraps > 0 && mf == 1 && mz == 0 && mx == 2) done = 1'b1;
    end
    chk(fn_wraps == 1, "R4", fn_wraps, 1);
    // R12: reset taken mid-frame with the strobe still high
    word_stb = 1'b1;
    rst = 1'b1;
    @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    word_stb = 1'b0;
    mw = 0; mx = 0; mz = 0; mf = 0;
    chk(w_idx == '0 && x_idx == '0 && z_idx == '0 && frame_num == '0, "R12",
        int'({w_idx, x_idx, z_idx, frame_num}), 0);
    check_slot();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog actual=%0d expected=%0d", 200000, 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule